// File: doc/BRIEF.md
# Write-Absorbing Hybrid Memory Cache Controller

This block is the tag and control unit of a set-associative cache that puts a fast DRAM array in front of a slow non-volatile main memory. The DRAM array exists only to soak up writes coming from the last-level cache. Each request from that cache is looked up in a tag store that holds a valid and a dirty bit for every line. A hit, whether it is a read or a write, is served from the DRAM array, so data that has not yet gone back to main memory stays coherent. A read miss goes straight to the slow memory and leaves the cache untouched. A write miss installs a line. If that replaces a dirty line, the whole old line is first written back to the slow memory.

The block handles one request at a time. It accepts a request when `req_ready` is high, reports the lookup result one cycle later, and then drives exactly one of three downstream request/acknowledge ports: the DRAM array, the slow-memory read port, or the write-back port. When a write-back is needed, the write-back port is driven first and the DRAM port follows it. The DRAM and slow-memory devices themselves are outside the block.

Top module: `wocache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `dram_valid`, `mem_valid` and `wb_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` is 1 for exactly the following cycle, and in that cycle it carries `rsp_hit`, `rsp_way` and `rsp_cache` (1 = DRAM cache, 0 = slow memory).
- R3: A request whose tag matches a valid line of its set reports `rsp_hit`=1, `rsp_cache`=1 and the matching way. It is then issued on the DRAM port with that set and way and with `dram_write` equal to the request's direction. The slow memory is not accessed.
- R4: A read miss reports `rsp_hit`=0, `rsp_cache`=0 and `rsp_way`=0. It issues one slow-memory read at the line-aligned address, holding `mem_valid` and `mem_addr` steady until `mem_ack`. It installs nothing and evicts nothing, so a repeat of the same read misses again.
- R5: A write miss reports `rsp_hit`=0 and `rsp_cache`=1. It installs the line, dirty, in the victim way reported in `rsp_way` and issues a DRAM write to that way. A later access to the line hits in that way.
- R6: When a set has an invalid way, the victim is the invalid way with the lowest index.
- R7: When all ways of a set are valid, the victim comes from a per-set round-robin pointer. The pointer starts at way 0 and advances by one, wrapping, on each such replacement in that set only.
- R8: Replacing a dirty line first raises `wb_valid` with the victim's line-aligned address (old tag, same set). The DRAM write follows only after `wb_ack`. Replacing an invalid or clean way produces no write-back.
- R9: The low log2(line bytes) = 6 address bits select a byte within the 64-byte line. They play no part in hit detection and are zero in `mem_addr` and `wb_addr`.
- R10: Between acceptance and the final downstream acknowledge, `req_ready` is 0 and a request held on the input is neither accepted nor installed. `req_ready` returns to 1 in the cycle after that acknowledge.
- R11: A write hit sets the line's dirty bit and produces no write-back. A read hit leaves the line state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Lookup result valid (one cycle) |
| rsp_hit | output | 1 | Tag matched a valid line |
| rsp_way | output | WAY_W | Hit way or allocated way |
| rsp_cache | output | 1 | 1 = served by DRAM cache, 0 = slow memory |
| dram_valid | output | 1 | DRAM array access request |
| dram_write | output | 1 | DRAM access direction |
| dram_set | output | SET_W | DRAM line set index |
| dram_way | output | WAY_W | DRAM line way index |
| dram_ack | input | 1 | DRAM access done |
| mem_valid | output | 1 | Slow-memory read request |
| mem_addr | output | ADDR_W | Line-aligned read address |
| mem_ack | input | 1 | Slow-memory read done |
| wb_valid | output | 1 | Dirty-line write-back request |
| wb_addr | output | ADDR_W | Line-aligned victim address |
| wb_ack | input | 1 | Write-back done |

## Verification
Some properties are checked on every cycle. The response appears only in the cycle after an acceptance, and the downstream ports are quiet while the block is idle. A hit or a write miss goes to DRAM or to write-back, and a read miss goes to the slow memory and holds its address until acknowledged. A write-back is always followed by a DRAM write. Other behaviour depends on stored state and is shown only by the bench's scenarios: that read misses leave no trace, which way is chosen first among free ways, and how the round-robin pointer advances independently per set. The bench also shows that a dirty victim's old address is written back and that a request held during a busy period is dropped.

// File: rtl/wocache_pkg.sv
package wocache_pkg;
  typedef enum logic [1:0] {
    WC_IDLE  = 2'd0,
    WC_CACHE = 2'd1,
    WC_SLOW  = 2'd2,
    WC_WBACK = 2'd3
  } wc_state_e;
endpackage

// File: rtl/wocache_tags.sv
module wocache_tags #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SET_W-1:0]            rd_set,
  input  logic [TAG_W-1:0]            cmp_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_dirty
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;
    logic             sel;

    assign sel = wr_en && (wr_way == WAY_W'(w));

    // tag array: no reset so it maps to distributed/block RAM
    always_ff @(posedge clk) begin
      if (sel) tag_mem[wr_set] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= '0;
        drt_q <= '0;
      end else if (sel) begin
        vld_q[wr_set] <= 1'b1;
        drt_q[wr_set] <= wr_dirty;
      end
    end

    assign rd_tag[w]   = tag_mem[rd_set];
    assign rd_valid[w] = vld_q[rd_set];
    assign rd_dirty[w] = drt_q[rd_set];
    assign hit_vec[w]  = vld_q[rd_set] && (tag_mem[rd_set] == cmp_tag);
  end
endmodule

// File: rtl/wocache_victim.sv
module wocache_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             advance,
  output logic [WAY_W-1:0] vic_way,
  output logic             set_full
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic [WAY_W-1:0] free_way;

  // lowest-index invalid way wins
  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) free_way = WAY_W'(w);
    end
  end

  assign set_full = &valid_vec;
  assign vic_way  = set_full ? rr_q[set_idx] : free_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (advance) begin
      rr_q[set_idx] <= (rr_q[set_idx] == WAY_W'(WAYS - 1)) ? '0 : rr_q[set_idx] + 1'b1;
    end
  end
endmodule

// File: rtl/wocache_ctrl.sv
module wocache_ctrl
  import wocache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_cache,
  output logic              dram_valid,
  output logic              dram_write,
  output logic [SET_W-1:0]  dram_set,
  output logic [WAY_W-1:0]  dram_way,
  input  logic              dram_ack,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  input  logic              wb_ack
);
  wc_state_e state_q, state_d;

  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic             acc;

  logic [WAYS-1:0]            hit_vec, rd_valid, rd_dirty;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic                       lk_hit;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           vic_way;
  logic                       set_full;
  logic                       vic_dirty;
  logic [TAG_W-1:0]           vic_tag;
  logic [WAY_W-1:0]           tgt_way;

  logic              cur_write_q;
  logic [SET_W-1:0]  cur_set_q;
  logic [WAY_W-1:0]  cur_way_q;
  logic [ADDR_W-1:0] mem_addr_q, wb_addr_q;

  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign acc     = req_valid && (state_q == WC_IDLE);

  wocache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_set   (req_set),
    .cmp_tag  (req_tag),
    .hit_vec  (hit_vec),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .wr_en    (acc && req_write),
    .wr_set   (req_set),
    .wr_way   (tgt_way),
    .wr_tag   (req_tag),
    .wr_dirty (1'b1)
  );

  wocache_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .set_idx   (req_set),
    .valid_vec (rd_valid),
    .advance   (acc && req_write && !lk_hit && set_full),
    .vic_way   (vic_way),
    .set_full  (set_full)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign lk_hit    = |hit_vec;
  assign tgt_way   = lk_hit ? hit_way : vic_way;
  assign vic_dirty = rd_valid[vic_way] && rd_dirty[vic_way];
  assign vic_tag   = rd_tag[vic_way];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WC_IDLE: begin
        if (acc) begin
          if (lk_hit)          state_d = WC_CACHE;
          else if (!req_write) state_d = WC_SLOW;
          else if (vic_dirty)  state_d = WC_WBACK;
          else                 state_d = WC_CACHE;
        end
      end
      WC_CACHE: if (dram_ack) state_d = WC_IDLE;
      WC_SLOW:  if (mem_ack)  state_d = WC_IDLE;
      WC_WBACK: if (wb_ack)   state_d = WC_CACHE;
      default:                state_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= WC_IDLE;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_way     <= '0;
      rsp_cache   <= 1'b0;
      cur_write_q <= 1'b0;
      cur_set_q   <= '0;
      cur_way_q   <= '0;
      mem_addr_q  <= '0;
      wb_addr_q   <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= acc;
      if (acc) begin
        rsp_hit     <= lk_hit;
        rsp_way     <= (lk_hit || req_write) ? tgt_way : '0;
        rsp_cache   <= lk_hit || req_write;
        cur_write_q <= req_write;
        cur_set_q   <= req_set;
        cur_way_q   <= tgt_way;
        mem_addr_q  <= {req_tag, req_set, {OFF_W{1'b0}}};
        wb_addr_q   <= {vic_tag, req_set, {OFF_W{1'b0}}};
      end
    end
  end

  assign req_ready  = (state_q == WC_IDLE);
  assign dram_valid = (state_q == WC_CACHE);
  assign dram_write = cur_write_q;
  assign dram_set   = cur_set_q;
  assign dram_way   = cur_way_q;
  assign mem_valid  = (state_q == WC_SLOW);
  assign mem_addr   = mem_addr_q;
  assign wb_valid   = (state_q == WC_WBACK);
  assign wb_addr    = wb_addr_q;
endmodule

// File: rtl/wocache_chk.sv
module wocache_chk #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [WAY_W-1:0]  rsp_way,
  input logic              rsp_cache,
  input logic              dram_valid,
  input logic              dram_write,
  input logic              dram_ack,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              wb_valid,
  input logic              wb_ack
);
  // R2
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !(dram_valid || mem_valid || wb_valid));

  // R3
  hit_route_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (dram_valid && rsp_cache && !mem_valid));

  // R4
  slow_route_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_cache) |-> (mem_valid && !rsp_hit && rsp_way == '0));

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_addr)));

  // R5
  wmiss_route_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && rsp_cache) |-> ((dram_valid && dram_write) || wb_valid));

  // R8
  wb_then_dram_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_ack) |=> (dram_valid && dram_write));
endmodule

bind wocache_ctrl wocache_chk #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_way    (rsp_way),
  .rsp_cache  (rsp_cache),
  .dram_valid (dram_valid),
  .dram_write (dram_write),
  .dram_ack   (dram_ack),
  .mem_valid  (mem_valid),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .wb_valid   (wb_valid),
  .wb_ack     (wb_ack)
);

// File: tb/sim_wocache_ctrl.sv
`timescale 1ns/1ps
module sim_wocache_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_cache;
  logic [1:0]  rsp_way;
  logic        dram_valid, dram_write;
  logic [3:0]  dram_set;
  logic [1:0]  dram_way;
  logic        mem_valid, wb_valid;
  logic [31:0] mem_addr, wb_addr;
  logic        dram_ack = 1'b0, mem_ack = 1'b0, wb_ack = 1'b0;

  int total = 0, bad = 0;
  int n_dram = 0, n_mem = 0, n_wb = 0;
  logic [1:0]  last_dram_way;
  logic        last_dram_wr;
  logic [31:0] last_mem_addr, last_wb_addr;

  always #2 clk = ~clk;

  wocache_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_cache(rsp_cache),
    .dram_valid(dram_valid), .dram_write(dram_write), .dram_set(dram_set),
    .dram_way(dram_way), .dram_ack(dram_ack), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .wb_valid(wb_valid),
    .wb_addr(wb_addr), .wb_ack(wb_ack)
  );

  // device models: acknowledge one cycle after a request shows up
  always @(negedge clk) begin
    if (dram_valid && !dram_ack) begin
      dram_ack = 1'b1; n_dram++; last_dram_way = dram_way; last_dram_wr = dram_write;
    end else dram_ack = 1'b0;
    if (mem_valid && !mem_ack) begin
      mem_ack = 1'b1; n_mem++; last_mem_addr = mem_addr;
    end else mem_ack = 1'b0;
    if (wb_valid && !wb_ack) begin
      wb_ack = 1'b1; n_wb++; last_wb_addr = wb_addr;
    end else wb_ack = 1'b0;
  end

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return {tag[21:0], set[3:0], off[5:0]};
  endfunction

  task automatic chk(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tg, what, act, exp);
    end
  endtask

  task automatic do_req(input string tg, input logic wr, input logic [31:0] a,
                        input logic e_hit, input int e_way, input logic e_cache,
                        input int e_wb, input logic [31:0] e_wb_addr);
    int d0, m0, w0;
    d0 = n_dram; m0 = n_mem; w0 = n_wb;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tg, "rsp_valid", 32'(rsp_valid), 32'd1);
    chk(tg, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
    chk(tg, "rsp_way", 32'(rsp_way), 32'(e_way));
    chk(tg, "rsp_cache", 32'(rsp_cache), 32'(e_cache));
    chk(tg, "busy ready", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(tg, "rsp pulse", 32'(rsp_valid), 32'd0);
    while (!req_ready) @(negedge clk);
    chk(tg, "mem count", 32'(n_mem - m0), e_cache ? 32'd0 : 32'd1);
    chk(tg, "wb count", 32'(n_wb - w0), 32'(e_wb));
    chk(tg, "dram count", 32'(n_dram - d0), e_cache ? 32'd1 : 32'd0);
    if (!e_cache) chk(tg, "mem addr", last_mem_addr, a & 32'hFFFF_FFC0);
    if (e_wb != 0) chk(tg, "wb addr", last_wb_addr, e_wb_addr);
    if (e_cache) begin
      chk(tg, "dram way", 32'(last_dram_way), 32'(e_way));
      chk(tg, "dram dir", 32'(last_dram_wr), 32'(wr));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ready", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "ports idle", {29'd0, dram_valid, mem_valid, wb_valid}, 32'd0);
  endtask

  task automatic t_read_bypass();
    // R4 read miss goes to slow memory and installs nothing (R1: cold miss)
    do_req("R4", 1'b0, mk(1, 1, 12), 1'b0, 0, 1'b0, 0, 0);
    do_req("R4", 1'b0, mk(1, 1, 12), 1'b0, 0, 1'b0, 0, 0);
  endtask

  task automatic t_write_alloc();
    // R5 R6 write miss allocates lowest free way; R9 offset ignored; R3 hit
    do_req("R5", 1'b1, mk(1, 1, 8), 1'b0, 0, 1'b1, 0, 0);
    do_req("R9", 1'b0, mk(1, 1, 40), 1'b1, 0, 1'b1, 0, 0);
    do_req("R6", 1'b1, mk(2, 1, 0), 1'b0, 1, 1'b1, 0, 0);
    do_req("R6", 1'b1, mk(3, 1, 0), 1'b0, 2, 1'b1, 0, 0);
    do_req("R6", 1'b1, mk(4, 1, 63), 1'b0, 3, 1'b1, 0, 0);
    do_req("R3", 1'b0, mk(3, 1, 4), 1'b1, 2, 1'b1, 0, 0);
  endtask

  task automatic t_replace();
    // R7 R8 full set: round robin from way 0, dirty victims written back
    do_req("R8", 1'b1, mk(5, 1, 0), 1'b0, 0, 1'b1, 1, mk(1, 1, 0));
    do_req("R7", 1'b1, mk(6, 1, 0), 1'b0, 1, 1'b1, 1, mk(2, 1, 0));
    do_req("R8", 1'b0, mk(1, 1, 0), 1'b0, 0, 1'b0, 0, 0);
    do_req("R3", 1'b0, mk(5, 1, 20), 1'b1, 0, 1'b1, 0, 0);
  endtask

  task automatic t_other_set();
    // R7 pointer of set 2 is independent of set 1
    do_req("R6", 1'b1, mk(7, 2, 0), 1'b0, 0, 1'b1, 0, 0);
    do_req("R6", 1'b1, mk(8, 2, 0), 1'b0, 1, 1'b1, 0, 0);
    do_req("R6", 1'b1, mk(9, 2, 0), 1'b0, 2, 1'b1, 0, 0);
    do_req("R6", 1'b1, mk(10, 2, 0), 1'b0, 3, 1'b1, 0, 0);
    do_req("R7", 1'b1, mk(11, 2, 0), 1'b0, 0, 1'b1, 1, mk(7, 2, 0));
    do_req("R7", 1'b1, mk(12, 1, 0), 1'b0, 2, 1'b1, 1, mk(3, 1, 0));
  endtask

  task automatic t_write_hit();
    // R11 write hit: dirty, no write-back, line stays
    do_req("R11", 1'b1, mk(11, 2, 16), 1'b1, 0, 1'b1, 0, 0);
    do_req("R11", 1'b0, mk(11, 2, 0), 1'b1, 0, 1'b1, 0, 0);
    do_req("R11", 1'b0, mk(11, 2, 0), 1'b1, 0, 1'b1, 0, 0);
  endtask

  task automatic t_busy_drop();
    int d0;
    // R10 request held during busy period is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    d0 = n_dram;
    req_valid = 1'b1; req_write = 1'b1; req_addr = mk(6, 1, 0);
    @(negedge clk);
    req_addr = mk(13, 5, 0);
    chk("R10", "ready busy", 32'(req_ready), 32'd0);
    chk("R3", "hit way", 32'(rsp_way), 32'd1);
    @(negedge clk);
    chk("R10", "ready back", 32'(req_ready), 32'd1);
    req_valid = 1'b0;
    chk("R10", "dram count", 32'(n_dram - d0), 32'd1);
    do_req("R10", 1'b0, mk(13, 5, 0), 1'b0, 0, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read_bypass();
    t_write_alloc();
    t_replace();
    t_other_set();
    t_write_hit();
    t_busy_drop();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule